// File: doc/BRIEF.md
# LUT-Based Logic Cell

This block models one programmable logic cell of a configurable fabric. Two four-input lookup tables (F and G) each evaluate an arbitrary function of their own four inputs. A three-input lookup table (H) then combines the F result, the G result and a separate input `h1`. Chaining the tables this way gives any five-variable function (with `h1` as the fifth variable) and some functions of up to nine variables.

Two combinational outputs, `x` and `y`, each pick between a first-level table result and the H result. Two storage elements, `xq` and `yq`, take their data from F, G, H or the bypass input `din`. They share one clock, one clock enable and one set/reset. A configuration bit switches both storage elements between edge-triggered flip-flops and level-sensitive latches. A global initialization input forces them to a chosen state at any time.

The configuration is written as one parallel word through `cfg_word`, qualified by `cfg_load`, before the cell is used.

Top module: `lut_cell`

## Requirements
- R1: The F result equals bit `f_tbl[f_in]` and the G result equals bit `g_tbl[g_in]`. `f_in[0]` and `g_in[0]` are the least significant index bits. `f_tbl` is `cfg_word[15:0]` and `g_tbl` is `cfg_word[31:16]`.
- R2: The H result equals bit `h_tbl[{h1, G, F}]`, with the F result as index bit 0. `h_tbl` is `cfg_word[39:32]`.
- R3: `x` shows F when `cfg_word[40]` is 0 and H when it is 1. `y` shows G when `cfg_word[41]` is 0 and H when it is 1.
- R4: The data input of `xq` is selected by `cfg_word[43:42]` and that of `yq` by `cfg_word[45:44]`. The codes are 0 for F, 1 for G, 2 for H and 3 for `din`.
- R5: When `cfg_word[48]` is 0 (flip-flop mode), a storage element loads its data on the rising edge of `clk` when `ce` is 1. It holds its value when `ce` is 0, and it never follows its data while `clk` is high.
- R6: In flip-flop mode, `sr` acts on the rising edge and overrides `ce`. It drives `xq` to the value of `cfg_word[46]` and `yq` to the value of `cfg_word[47]`.
- R7: `gsr` drives `xq` to `cfg_word[46]` and `yq` to `cfg_word[47]` at once, without waiting for a clock edge. It takes priority over `sr`, `ce` and the clock.
- R8: When `cfg_word[48]` is 1 (latch mode), a storage element follows its data while `clk` is high and `ce` is 1. While `clk` is high, `sr` forces the set/reset value. The element holds its value while `clk` is low, or while `clk` is high with `ce` at 0.
- R9: The configuration word is taken on the rising edge of `clk` when `cfg_load` is 1. Outputs keep following the previous configuration until that edge.
- R10: With F and G fed the same four inputs, `h1` as the fifth input and `h_tbl` set to 8'hCA, `x` (showing H) realises any 32-entry truth table. The table's low half goes in `f_tbl` and its high half in `g_tbl`.
- R11: `x` and `y` keep showing table results while the storage elements capture `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock of the storage elements; also the enable level in latch mode |
| gsr | input | 1 | Global asynchronous initialization, active high |
| cfg_load | input | 1 | Loads `cfg_word` on the rising clock edge |
| cfg_word | input | 49 | Parallel configuration word |
| f_in | input | 4 | Inputs of the F table |
| g_in | input | 4 | Inputs of the G table |
| h1 | input | 1 | Third input of the H table |
| din | input | 1 | Direct bypass data for the storage elements |
| ce | input | 1 | Shared clock enable |
| sr | input | 1 | Shared set/reset, active high |
| x | output | 1 | Combinational output, F or H |
| y | output | 1 | Combinational output, G or H |
| xq | output | 1 | First storage element output |
| yq | output | 1 | Second storage element output |

## Verification
The bench sweeps each table index. An index reversal or swapped H inputs would show up as wrong bits at `x` and `y`. It realises a random five-input function through the H cascade, which catches a wrong H index order. It checks that `sr` wins over `ce` and that `gsr` acts between clock edges, which catches a synchronous global initialization. In latch mode it changes `din` inside the high clock phase and the low clock phase: a flip-flop in place of a latch misses the change, and a latch that ignores `clk` passes it through. It also checks that a configuration change takes effect on the load edge and not before.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
    localparam int LUT_K   = 4;
    localparam int H_K     = 3;
    localparam int TBL_W   = 1 << LUT_K;
    localparam int H_TBL_W = 1 << H_K;
    localparam int N_STORE = 2;

    typedef enum logic [1:0] {
        DSRC_F   = 2'd0,
        DSRC_G   = 2'd1,
        DSRC_H   = 2'd2,
        DSRC_DIN = 2'd3
    } dsrc_e;

    typedef struct packed {
        logic               latch_mode;
        logic               y_set;
        logic               x_set;
        dsrc_e              yd_sel;
        dsrc_e              xd_sel;
        logic               y_sel;
        logic               x_sel;
        logic [H_TBL_W-1:0] h_tbl;
        logic [TBL_W-1:0]   g_tbl;
        logic [TBL_W-1:0]   f_tbl;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/lut_cell_lut.sv
module lut_cell_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] tbl,
    input  logic [K-1:0]      idx,
    output logic              o
);
    assign o = tbl[idx];
endmodule

// File: rtl/lut_cell_store.sv
module lut_cell_store (
    input  logic clk,
    input  logic gsr,
    input  logic latch_mode,
    input  logic set_val,
    input  logic ce,
    input  logic sr,
    input  logic d,
    output logic q
);
    logic ff_d, ff_q, lat_q;

    always_comb begin
        ff_d = ff_q;
        if (sr)      ff_d = set_val;
        else if (ce) ff_d = d;
    end

    always_ff @(posedge clk or posedge gsr) begin
        if (gsr) ff_q <= set_val;
        else     ff_q <= ff_d;
    end

    always_latch begin
        if (gsr)             lat_q <= set_val;
        else if (clk && sr)  lat_q <= set_val;
        else if (clk && ce)  lat_q <= d;
    end

    assign q = latch_mode ? lat_q : ff_q;
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lut_cell_pkg::*;
(
    input  logic             clk,
    input  logic             gsr,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             h1,
    input  logic             din,
    input  logic             ce,
    input  logic             sr,
    output logic             x,
    output logic             y,
    output logic             xq,
    output logic             yq
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_load) cfg_d = cfg_t'(cfg_word);
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    logic f_v, g_v, h_v;

    lut_cell_lut #(.K(LUT_K)) u_f (.tbl(cfg_q.f_tbl), .idx(f_in), .o(f_v));
    lut_cell_lut #(.K(LUT_K)) u_g (.tbl(cfg_q.g_tbl), .idx(g_in), .o(g_v));
    lut_cell_lut #(.K(H_K))   u_h (.tbl(cfg_q.h_tbl), .idx({h1, g_v, f_v}), .o(h_v));

    assign x = cfg_q.x_sel ? h_v : f_v;
    assign y = cfg_q.y_sel ? h_v : g_v;

    function automatic logic pick_src(dsrc_e s, logic fv, logic gv, logic hv, logic dv);
        case (s)
            DSRC_F:  return fv;
            DSRC_G:  return gv;
            DSRC_H:  return hv;
            default: return dv;
        endcase
    endfunction

    dsrc_e              st_sel [N_STORE];
    logic [N_STORE-1:0] st_set;
    logic [N_STORE-1:0] st_d;
    logic [N_STORE-1:0] st_q;
    logic               mode_w;

    assign st_sel[0] = cfg_q.xd_sel;
    assign st_sel[1] = cfg_q.yd_sel;
    assign st_set[0] = cfg_q.x_set;
    assign st_set[1] = cfg_q.y_set;
    assign mode_w    = cfg_q.latch_mode;

    for (genvar i = 0; i < N_STORE; i++) begin : g_st
        assign st_d[i] = pick_src(st_sel[i], f_v, g_v, h_v, din);
        lut_cell_store u_st (
            .clk        (clk),
            .gsr        (gsr),
            .latch_mode (mode_w),
            .set_val    (st_set[i]),
            .ce         (ce),
            .sr         (sr),
            .d          (st_d[i]),
            .q          (st_q[i])
        );
    end

    assign xq = st_q[0];
    assign yq = st_q[1];
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
    input logic clk,
    input logic gsr,
    input logic cfg_load,
    input logic latch_mode,
    input logic x_set,
    input logic y_set,
    input logic ce,
    input logic sr,
    input logic xd,
    input logic xq,
    input logic yq
);
    p_ff_hold_r5: assert property (@(posedge clk) disable iff (gsr)
        (!latch_mode && !cfg_load && !sr && !ce) |=> $stable(xq));

    p_ff_capture_r4: assert property (@(posedge clk) disable iff (gsr)
        (!latch_mode && !cfg_load && !sr && ce) |=> (xq == $past(xd)));

    p_sr_force_x_r6: assert property (@(posedge clk) disable iff (gsr)
        (!latch_mode && !cfg_load && sr) |=> (xq == $past(x_set)));

    p_sr_force_y_r6: assert property (@(posedge clk) disable iff (gsr)
        (!latch_mode && !cfg_load && sr) |=> (yq == $past(y_set)));

    p_gsr_init_r7: assert property (@(posedge clk) disable iff (cfg_load)
        (gsr && !$past(cfg_load)) |-> (xq == x_set && yq == y_set));
endmodule

bind lut_cell lut_cell_chk u_chk (
    .clk        (clk),
    .gsr        (gsr),
    .cfg_load   (cfg_load),
    .latch_mode (mode_w),
    .x_set      (st_set[0]),
    .y_set      (st_set[1]),
    .ce         (ce),
    .sr         (sr),
    .xd         (st_d[0]),
    .xq         (xq),
    .yq         (yq)
);

// File: tb/lut_cell_bench.sv
`timescale 1ns/100ps
module lut_cell_bench;
    logic        clk = 1'b0;
    logic        gsr = 1'b0;
    logic        cfg_load = 1'b0;
    logic [48:0] cfg_word = '0;
    logic [3:0]  f_in = '0, g_in = '0;
    logic        h1 = 1'b0, din = 1'b0, ce = 1'b0, sr = 1'b0;
    logic        x, y, xq, yq;

    always #2 clk = ~clk;

    lut_cell u_lut_cell (
        .clk(clk), .gsr(gsr), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .f_in(f_in), .g_in(g_in), .h1(h1), .din(din), .ce(ce), .sr(sr),
        .x(x), .y(y), .xq(xq), .yq(yq)
    );

    // model configuration and state
    logic [15:0] mf, mg;
    logic [7:0]  mh;
    logic        mxsl, mysl, mxs, mys, mlm;
    logic [1:0]  mxd, myd;
    logic        xqm, yqm;
    int          errs = 0, checks = 0;
    bit          done = 0;

    function automatic logic [48:0] cfg_vec();
        return {mlm, mys, mxs, myd, mxd, mysl, mxsl, mh, mg, mf};
    endfunction

    function automatic logic src_of(logic [1:0] s, logic fv, logic gv, logic hv, logic dv);
        if (s == 2'd0) return fv;
        if (s == 2'd1) return gv;
        if (s == 2'd2) return hv;
        return dv;
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic load_cfg();
        @(negedge clk);
        cfg_word = cfg_vec(); cfg_load = 1; ce = 0; sr = 0;
        @(negedge clk);
        cfg_load = 0; gsr = 1;
        @(negedge clk);
        gsr = 0;
        xqm = mxs; yqm = mys;
    endtask

    task automatic step(logic [3:0] fa, logic [3:0] ga, logic h, logic dn,
                        logic c, logic s, string xytag);
        logic fv, gv, hv;
        string qtag;
        @(negedge clk);
        f_in = fa; g_in = ga; h1 = h; din = dn; ce = c; sr = s;
        @(posedge clk);
        fv = mf[fa]; gv = mg[ga]; hv = mh[{h, gv, fv}];
        if (s) begin
            xqm = mxs; yqm = mys;
        end else if (c) begin
            xqm = src_of(mxd, fv, gv, hv, dn);
            yqm = src_of(myd, fv, gv, hv, dn);
        end
        qtag = s ? "R6" : (c ? (mlm ? "R8" : "R4") : "R5");
        #1;
        chk(xytag, "x", x, mxsl ? hv : fv);
        chk(xytag, "y", y, mysl ? hv : gv);
        chk(qtag, "xq", xq, xqm);
        chk(qtag, "yq", yq, yqm);
    endtask

    task automatic rnd_cfg();
        mf = 16'($urandom); mg = 16'($urandom); mh = 8'($urandom);
        mxsl = 1'($urandom); mysl = 1'($urandom);
        mxs = 1'($urandom); mys = 1'($urandom); mlm = 1'($urandom);
        mxd = 2'($urandom); myd = 2'($urandom);
    endtask

    initial begin
        logic [31:0] tt;
        // reset state R7
        rnd_cfg(); mlm = 0; mxs = 1; mys = 0;
        load_cfg();
        #0.5;
        chk("R7", "xq after gsr", xq, 1'b1);
        chk("R7", "yq after gsr", yq, 1'b0);

        // R1 sweep of F and G indices
        rnd_cfg(); mlm = 0; mxsl = 0; mysl = 0;
        load_cfg();
        for (int i = 0; i < 16; i++) step(4'(i), 4'(15 - i), 1'($urandom), 0, 0, 0, "R1");

        // R2 H table
        rnd_cfg(); mlm = 0; mxsl = 1; mysl = 1;
        load_cfg();
        for (int i = 0; i < 32; i++)
            step(4'($urandom), 4'($urandom), 1'(i >> 4), 1'($urandom), 0, 0, "R2");

        // R9 configuration load timing
        rnd_cfg(); mlm = 0; mf = 16'h0000; mxsl = 0;
        load_cfg();
        @(negedge clk);
        f_in = 4'd5; ce = 0; sr = 0;
        mf = 16'hFFFF; cfg_word = cfg_vec(); cfg_load = 1;
        #0.5;
        chk("R9", "x before load edge", x, 1'b0);
        @(posedge clk); #1;
        chk("R9", "x after load edge", x, 1'b1);
        @(negedge clk); cfg_load = 0;

        // R10 five-input function through the cascade
        tt = $urandom;
        rnd_cfg(); mlm = 0; mf = tt[15:0]; mg = tt[31:16]; mh = 8'hCA; mxsl = 1;
        load_cfg();
        for (int v = 0; v < 32; v++) begin
            step(4'(v), 4'(v), 1'(v >> 4), 0, 0, 0, "R10");
            chk("R10", "x five-input", x, tt[v]);
        end

        // R11 combinational outputs independent of stored bypass data
        rnd_cfg(); mlm = 0; mxd = 2'd3; myd = 2'd3; mxsl = 0; mysl = 0;
        load_cfg();
        for (int i = 0; i < 16; i++)
            step(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 1, 0, "R11");

        // R7 asynchronous global initialization
        rnd_cfg(); mlm = 0; mxd = 2'd3; myd = 2'd3; mxs = 1; mys = 1;
        load_cfg();
        step(0, 0, 0, 0, 1, 0, "R3");
        @(negedge clk); #0.5;
        gsr = 1; #0.5;
        chk("R7", "xq async", xq, 1'b1);
        chk("R7", "yq async", yq, 1'b1);
        @(negedge clk); gsr = 0;

        // R8 latch transparency
        rnd_cfg(); mlm = 1; mxd = 2'd3; myd = 2'd3; mxs = 0; mys = 0;
        load_cfg();
        step(0, 0, 0, 0, 1, 0, "R3");
        din = 1; #0.3;
        chk("R8", "xq transparent in high phase", xq, 1'b1);
        @(negedge clk); #0.2;
        din = 0; #0.3;
        chk("R8", "xq held in low phase", xq, 1'b1);
        ce = 0;
        @(posedge clk); #0.5;
        chk("R8", "xq held with ce low", xq, 1'b1);
        sr = 1; #0.3;
        chk("R8", "sr forces in high phase", xq, 1'b0);
        @(negedge clk); sr = 0;

        // R5 flip-flop does not follow data in high phase
        rnd_cfg(); mlm = 0; mxd = 2'd3; myd = 2'd3;
        load_cfg();
        step(0, 0, 0, 0, 1, 0, "R3");
        din = 1; #0.3;
        chk("R5", "xq not transparent", xq, 1'b0);
        @(negedge clk); din = 0;

        // random configurations: R3 R4 R5 R6 R8
        for (int c = 0; c < 10; c++) begin
            rnd_cfg();
            load_cfg();
            for (int v = 0; v < 40; v++)
                step(4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom % 4) != 0, ($urandom % 8) == 0, "R3");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule